// File: doc/BRIEF.md
# Branch and Loop Condition Evaluator

This block decides, within the same cycle, whether a conditional control transfer is taken. A decoder presents a 5-bit condition select, the current arithmetic flags (carry, zero, sign, overflow, parity) and the count register. The block answers with a take signal. For the counted-loop forms it also supplies the decremented count and a write strobe for the register file.

The first sixteen select codes are flag conditions. Bit 0 of such a code inverts the base condition named by bits 3:1, so each condition and its opposite are neighbours. The select space also covers a jump taken when the count is zero and three counted loops. The loops decrement the count first and then test the new value: one tests only the count, one also needs the zero flag set, and one also needs it clear. Alias mnemonics share one code. The block never drives a flag. It computes no target and generates no flags.

Top module: `branch_cond_eval`

## Requirements
- R1: Unsigned codes: 2 (below) is taken when cf=1; 6 (below-or-equal) is taken when cf=1 or zf=1.
- R2: Signed codes: 12 (less) is taken when sf differs from of; 14 (less-or-equal) is taken when sf differs from of or zf=1.
- R3: Single-flag codes: 0 is taken when of=1, 4 when zf=1, 8 when sf=1, 10 when pf=1.
- R4: Each odd code 1,3,...,15 is taken exactly when the even code one below it is not taken. So 3 is above-or-equal, 7 is above (cf=0 and zf=0), 13 is greater-or-equal, and 15 is greater (zf=0 and sf equal to of).
- R5: Code 16 (count-zero jump) is taken exactly when cx is 0. It leaves cx unchanged: cx_we=0.
- R6: Code 17 (plain loop) asserts cx_we, drives cx_next = cx-1, and is taken when cx_next is nonzero.
- R7: Code 18 (loop while equal) also needs zf=1 to be taken. Code 19 (loop while not equal) also needs zf=0. Both decrement cx as in R6.
- R8: A loop entered with cx=0 wraps cx_next to all ones and is taken whenever its zero-flag requirement holds.
- R9: Codes 20 to 31 are never taken and never write cx.
- R10: For codes 0 to 16, cx_we is 0 and cx_next equals cx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cond_sel | input | 5 | Condition select: 0-15 flag tests, 16 count-zero jump, 17-19 loops |
| cf | input | 1 | Carry flag |
| zf | input | 1 | Zero flag |
| sf | input | 1 | Sign flag |
| of | input | 1 | Overflow flag |
| pf | input | 1 | Parity flag |
| cx | input | CX_W | Current count register |
| take | output | 1 | Transfer is taken |
| cx_next | output | CX_W | Value to write back to the count register |
| cx_we | output | 1 | Count register write enable |

## Verification
The bound checker looks at every evaluation. It checks that the below and less tests follow their flags, that the count-zero jump never writes, that every loop writes exactly cx-1 and wraps from zero, that a loop while equal is not taken with zf clear, and that unused codes stay silent. The inversion pairing between odd and even codes, the compound conditions (above, greater, less-or-equal) under every flag combination, and the loop boundaries at cx of 1 and 0 are shown only by the bench's scenarios. The bench sweeps all 32 flag combinations for each flag code and applies chosen counts for each loop form.

// File: rtl/branch_cond_eval.sv
module branch_cond_eval #(
  parameter int CX_W = 16
) (
  input  logic [4:0]      cond_sel,
  input  logic            cf,
  input  logic            zf,
  input  logic            sf,
  input  logic            of,
  input  logic            pf,
  input  logic [CX_W-1:0] cx,
  output logic            take,
  output logic [CX_W-1:0] cx_next,
  output logic            cx_we
);
  localparam logic [4:0] SEL_CXZ    = 5'd16;
  localparam logic [4:0] SEL_LOOP   = 5'd17;
  localparam logic [4:0] SEL_LOOPE  = 5'd18;
  localparam logic [4:0] SEL_LOOPNE = 5'd19;
  localparam logic [CX_W-1:0] CX_ONE = CX_W'(1);

  logic            base_hit;
  logic            flag_hit;
  logic            is_flag;
  logic            is_loop;
  logic            loop_hit;
  logic [CX_W-1:0] cx_dec;
  logic            lt_signed;

  assign lt_signed = sf ^ of;
  assign cx_dec    = cx - CX_ONE;
  assign is_flag   = ~cond_sel[4];
  assign is_loop   = (cond_sel == SEL_LOOP) || (cond_sel == SEL_LOOPE) ||
                     (cond_sel == SEL_LOOPNE);

  always_comb begin
    case (cond_sel[3:1])
      3'd0:    base_hit = of;
      3'd1:    base_hit = cf;
      3'd2:    base_hit = zf;
      3'd3:    base_hit = cf | zf;
      3'd4:    base_hit = sf;
      3'd5:    base_hit = pf;
      3'd6:    base_hit = lt_signed;
      default: base_hit = lt_signed | zf;
    endcase
  end

  assign flag_hit = base_hit ^ cond_sel[0];

  always_comb begin
    case (cond_sel)
      SEL_LOOP:   loop_hit = |cx_dec;
      SEL_LOOPE:  loop_hit = (|cx_dec) & zf;
      SEL_LOOPNE: loop_hit = (|cx_dec) & ~zf;
      default:    loop_hit = 1'b0;
    endcase
  end

  assign take    = is_flag ? flag_hit :
                   (cond_sel == SEL_CXZ) ? ~(|cx) : loop_hit;
  assign cx_we   = is_loop;
  assign cx_next = is_loop ? cx_dec : cx;
endmodule

module branch_cond_eval_chk #(
  parameter int CX_W = 16
) (
  input logic [4:0]      cond_sel,
  input logic            cf,
  input logic            zf,
  input logic            sf,
  input logic            of,
  input logic            pf,
  input logic [CX_W-1:0] cx,
  input logic            take,
  input logic [CX_W-1:0] cx_next,
  input logic            cx_we
);
  logic in_loop;
  assign in_loop = (cond_sel >= 5'd17) && (cond_sel <= 5'd19);

  always_comb begin
    if (cond_sel == 5'd2)
      a_r1_below_carry: assert (take == cf);
    if (cond_sel == 5'd12)
      a_r2_less_signs: assert (take == (sf != of));
    if (cond_sel == 5'd16)
      a_r5_cxz_no_write: assert (!cx_we && (take == (cx == '0)));
    if (in_loop)
      a_r6_loop_decrements: assert (cx_we && (cx_next + CX_W'(1) == cx));
    if (cond_sel == 5'd18 && !zf)
      a_r7_loope_needs_zero: assert (!take);
    if (in_loop && cx == '0)
      a_r8_loop_wraps: assert (&cx_next);
    if (cond_sel >= 5'd20)
      a_r9_unused_silent: assert (!take && !cx_we);
    if (cond_sel <= 5'd16)
      a_r10_flag_cx_hold: assert (!cx_we && cx_next == cx);
  end
endmodule

bind branch_cond_eval branch_cond_eval_chk #(.CX_W(CX_W)) u_chk (
  .cond_sel(cond_sel), .cf(cf), .zf(zf), .sf(sf), .of(of), .pf(pf),
  .cx(cx), .take(take), .cx_next(cx_next), .cx_we(cx_we)
);

// File: tb/tb_branch_cond_eval.sv
module tb_branch_cond_eval;
  localparam int CX_W = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [4:0]      cond_sel;
  logic            cf, zf, sf, of, pf;
  logic [CX_W-1:0] cx;
  logic            take, cx_we;
  logic [CX_W-1:0] cx_next;

  branch_cond_eval #(.CX_W(CX_W)) dut (
    .cond_sel(cond_sel), .cf(cf), .zf(zf), .sf(sf), .of(of), .pf(pf),
    .cx(cx), .take(take), .cx_next(cx_next), .cx_we(cx_we)
  );

  typedef struct {
    logic            take;
    logic            we;
    logic [CX_W-1:0] cxn;
    string           req;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  function automatic logic ref_flag(input logic [3:0] c, input logic [4:0] f);
    logic vc, vz, vs, vo, vp, r;
    {vc, vz, vs, vo, vp} = f;
    case (c)
      4'd0:  r = vo;              4'd1:  r = !vo;
      4'd2:  r = vc;              4'd3:  r = !vc;
      4'd4:  r = vz;              4'd5:  r = !vz;
      4'd6:  r = vc || vz;        4'd7:  r = !vc && !vz;
      4'd8:  r = vs;              4'd9:  r = !vs;
      4'd10: r = vp;              4'd11: r = !vp;
      4'd12: r = vs != vo;        4'd13: r = vs == vo;
      4'd14: r = (vs != vo) || vz;
      default: r = !vz && (vs == vo);
    endcase
    return r;
  endfunction

  task automatic drive(input logic [4:0] s, input logic [4:0] f,
                       input logic [CX_W-1:0] c, input string req);
    exp_t e;
    @(posedge clk);
    cond_sel = s;
    {cf, zf, sf, of, pf} = f;
    cx = c;
    e.req = req;
    if (s < 5'd16) begin
      e.take = ref_flag(s[3:0], f); e.we = 1'b0; e.cxn = c;
    end else if (s == 5'd16) begin
      e.take = (c == 0); e.we = 1'b0; e.cxn = c;
    end else if (s <= 5'd19) begin
      e.cxn = c - 1;
      e.we  = 1'b1;
      e.take = (e.cxn != 0) &&
               ((s == 5'd17) || (s == 5'd18 && f[3]) || (s == 5'd19 && !f[3]));
    end else begin
      e.take = 1'b0; e.we = 1'b0; e.cxn = c;
    end
    exp_q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_vec++;
      if (take !== e.take || cx_we !== e.we || cx_next !== e.cxn) begin
        n_fail++;
        $display("FAIL %s sel=%0d: take=%b we=%b cx_next=%h, expected take=%b we=%b cx_next=%h",
                 e.req, cond_sel, take, cx_we, cx_next, e.take, e.we, e.cxn);
      end
    end
  end

  function automatic string tag_of(input logic [4:0] s);
    if (s[0] && s < 5'd16) return "R4";
    case (s)
      5'd2, 5'd6:         return "R1";
      5'd12, 5'd14:       return "R2";
      default:            return "R3";
    endcase
  endfunction

  initial begin
    cond_sel = 5'd20; {cf, zf, sf, of, pf} = '0; cx = '0;
    // R9 idle state at start
    drive(5'd20, 5'b11111, 16'h0000, "R9");
    for (int s = 0; s < 16; s++)
      for (int f = 0; f < 32; f++)
        drive(5'(s), 5'(f), 16'h1234, tag_of(5'(s)));
    // R10 cx passes through on flag codes
    drive(5'd7, 5'b00000, 16'hBEEF, "R10");
    // R5 count-zero jump
    drive(5'd16, 5'b01000, 16'h0000, "R5");
    drive(5'd16, 5'b00000, 16'h0001, "R5");
    drive(5'd16, 5'b11111, 16'hFFFF, "R5");
    // R6 plain loop
    drive(5'd17, 5'b00000, 16'h0005, "R6");
    drive(5'd17, 5'b01000, 16'h0001, "R6");
    drive(5'd17, 5'b11111, 16'h0002, "R6");
    // R7 zero-flag qualified loops
    for (int z = 0; z < 2; z++) begin
      drive(5'd18, z ? 5'b01000 : 5'b10111, 16'h0003, "R7");
      drive(5'd19, z ? 5'b01000 : 5'b10111, 16'h0003, "R7");
      drive(5'd18, z ? 5'b01000 : 5'b10111, 16'h0001, "R7");
      drive(5'd19, z ? 5'b01000 : 5'b10111, 16'h0001, "R7");
    end
    // R8 wrap from zero
    drive(5'd17, 5'b00000, 16'h0000, "R8");
    drive(5'd18, 5'b01000, 16'h0000, "R8");
    drive(5'd18, 5'b00000, 16'h0000, "R8");
    drive(5'd19, 5'b00000, 16'h0000, "R8");
    drive(5'd19, 5'b01000, 16'h0000, "R8");
    // R9 unused codes
    for (int s = 20; s < 32; s++)
      drive(5'(s), 5'(s), 16'h0001, "R9");
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule